// File: doc/BRIEF.md
# Binary32 to Integer Converter with Selectable Rounding

This block takes a packed single-precision floating-point word and turns it into a 32-bit integer, either unsigned or two's-complement signed. One control selects the integer form, a two-bit field selects the rounding direction, and a separate override bit makes the conversion truncate no matter what the rounding field says. Three status flags come back with the result: invalid operation, inexact result, and denormal operand.

Internally the input is classified first: NaN, an exponent too large for any 32-bit integer, an in-range value, or a magnitude below one half. For in-range values, one shift chosen by the exponent splits the significand into an integer part and a 32-bit fraction word. A rounding increment that depends on the mode, the sign and the integer's low bit is added to the fraction, and a carry out of that sum bumps the integer. Saturation and the invalid flag then follow rules that differ between the signed and unsigned forms. One of these differences shows up for tiny negative values rounded toward minus infinity.

A request is a single-cycle `in_valid` strobe. The result and flags are registered and appear one clock later with a one-cycle `out_valid` pulse. They stay unchanged until the next request.

Top module: `f2i_round_conv`

## Requirements
- R1: Each cycle with `in_valid` high produces exactly one `out_valid` pulse in the next cycle, carrying that request's result and flags. Without a request, `out_int` and the flags keep their values. After reset every output is zero.
- R2: `flag_denorm` is set exactly when the exponent field (bits 30:23) is zero and the fraction field (bits 22:0) is not zero. Bit 31 is the sign.
- R3: If the exponent field is 159 or more and the input is not a NaN, `flag_invalid` is set and `flag_inexact` is clear. Unsigned gives 0xFFFFFFFF for a positive input and 0 for a negative one. Signed gives 0x7FFFFFFF for a positive input and 0x80000000 for a negative one.
- R4: For a NaN (exponent field 255, fraction nonzero), unsigned gives 0xFFFFFFFF whatever the sign bit, and signed gives 0. `flag_invalid` is set in both cases.
- R5: `rmode` encodings: 00 = nearest with ties to even, 01 = toward plus infinity, 10 = toward minus infinity, 11 = toward zero. For exponents 126 to 158, the result is the correctly rounded value. `flag_inexact` is set when the discarded fraction is nonzero, unless the result was saturated or forced to zero.
- R6: When `force_rz` is high the conversion truncates toward zero, and `rmode` has no effect on the result or the flags.
- R7: Unsigned form with a negative in-range input: if the rounded magnitude is nonzero, the result is 0 with `flag_invalid` set and `flag_inexact` clear. If the magnitude rounds to zero, the result is 0 and `flag_inexact` follows the discarded fraction.
- R8: Signed form: a rounded magnitude above 2^31−1 (positive) or above 2^31 (negative) saturates to 0x7FFFFFFF or 0x80000000 and sets `flag_invalid`. Otherwise a negative input gives the two's complement of the magnitude.
- R9: A nonzero input with exponent field below 126 gives 0 with `flag_inexact`. There are two exceptions. Toward plus infinity with a positive input gives 1. Toward minus infinity with a negative input gives 0xFFFFFFFF when signed, and 0 with both `flag_invalid` and `flag_inexact` when unsigned. A zero input of either sign gives 0 with no invalid or inexact flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Conversion request strobe |
| in_word | input | 32 | Packed binary32 operand |
| to_signed | input | 1 | 1 = signed result, 0 = unsigned result |
| rmode | input | 2 | Rounding direction (see R5) |
| force_rz | input | 1 | Truncate regardless of `rmode` |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_int | output | 32 | Converted integer |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_inexact | output | 1 | Inexact-result flag |
| flag_denorm | output | 1 | Denormal-operand flag |

## Verification
Any fault in this block shows up on the result register one clock after the request and nowhere else. A wrong shift count or rounding increment gives an integer that is off by one or by a power of two. A wrong class decision gives a saturated value or a clear invalid flag where the other was expected. The bench drives directed boundary values under every combination of mode, form and override, including ties, half values, 2^31 and 2^32, tiny values of both signs, NaNs and infinities. It then drives a random sweep of exponents around the integer range and compares every output on every clock against a model that computes the value by exact integer arithmetic. A corrupted hold path shows up in the first idle cycle, because the outputs are also compared when no result is due.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int BIAS   = 127;
    localparam int INT_W  = 32;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_UP   = 2'b01,
        RM_DOWN = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    // Operand classification produced by the aligner
    typedef struct packed {
        logic sign;
        logic is_nan;
        logic is_big;     // exponent too large for any 32-bit integer
        logic is_tiny;    // magnitude below one half (includes zero, denormals)
        logic is_zero;
        logic is_denorm;
    } fclass_t;

    // Registered output bundle
    typedef struct packed {
        logic             vld;
        logic [INT_W-1:0] res;
        logic             inv;
        logic             inx;
        logic             den;
    } conv_out_t;
endpackage

// File: rtl/f2i_align.sv
module f2i_align
    import f2i_pkg::*;
#(
    parameter int P_EXP_W  = EXP_W,
    parameter int P_FRAC_W = FRAC_W,
    parameter int P_INT_W  = INT_W,
    parameter int P_BIAS   = BIAS
) (
    input  logic [P_EXP_W+P_FRAC_W:0] word,
    output fclass_t                   cls,
    output logic [P_INT_W-1:0]        ipart,
    output logic [P_INT_W-1:0]        rem
);
    localparam int SIG_W   = P_FRAC_W + 1;
    localparam int PAD_W   = P_INT_W - SIG_W;
    localparam int SH_W    = $clog2(P_INT_W + 1);
    localparam int LOW_EXP = P_BIAS - 1;             // smallest exponent handled by shifting
    localparam int TOP_EXP = P_BIAS + P_INT_W - 1;   // shift of zero
    localparam int BIG_EXP = P_BIAS + P_INT_W;       // saturating exponent

    logic [P_EXP_W-1:0]     exp_f;
    logic [P_FRAC_W-1:0]    frac_f;
    logic                   frac_nz;
    logic                   exp_zero;
    logic                   in_range;
    logic [P_EXP_W:0]       diff;
    logic [SH_W-1:0]        sh;
    logic [P_INT_W-1:0]     sig_top;
    logic [2*P_INT_W-1:0]   wide;

    assign exp_f    = word[P_EXP_W+P_FRAC_W-1 -: P_EXP_W];
    assign frac_f   = word[P_FRAC_W-1:0];
    assign frac_nz  = |frac_f;
    assign exp_zero = ~|exp_f;

    assign cls.sign      = word[P_EXP_W+P_FRAC_W];
    assign cls.is_nan    = (&exp_f) && frac_nz;
    assign cls.is_big    = exp_f >= P_EXP_W'(BIG_EXP);
    assign cls.is_tiny   = exp_f <  P_EXP_W'(LOW_EXP);
    assign cls.is_zero   = exp_zero && !frac_nz;
    assign cls.is_denorm = exp_zero && frac_nz;

    assign in_range = (exp_f >= P_EXP_W'(LOW_EXP)) && (exp_f <= P_EXP_W'(TOP_EXP));
    assign diff     = (P_EXP_W+1)'(TOP_EXP) - {1'b0, exp_f};
    assign sh       = in_range ? diff[SH_W-1:0] : '0;

    // Hidden bit at the top of the word, fraction below it
    generate
        if (PAD_W > 0) begin : g_pad
            assign sig_top = {!exp_zero, frac_f, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign sig_top = {!exp_zero, frac_f};
        end
    endgenerate

    // Upper half is the integer part, lower half holds the bits shifted out
    assign wide  = {sig_top, {P_INT_W{1'b0}}} >> sh;
    assign ipart = wide[2*P_INT_W-1:P_INT_W];
    assign rem   = wide[P_INT_W-1:0];
endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
#(
    parameter int P_INT_W = INT_W
) (
    input  logic [P_INT_W-1:0] ipart,
    input  logic [P_INT_W-1:0] rem,
    input  rmode_e             mode,
    input  logic               neg,
    output logic               carry
);
    logic [P_INT_W-1:0] incr;
    logic [P_INT_W:0]   sum;

    always_comb begin
        unique case (mode)
            RM_NEAR: incr = ipart[0] ? {1'b1, {(P_INT_W-1){1'b0}}}
                                     : {1'b0, {(P_INT_W-1){1'b1}}};
            RM_UP:   incr = neg ? '0 : '1;
            RM_DOWN: incr = neg ? '1 : '0;
            default: incr = '0;
        endcase
    end

    assign sum   = {1'b0, rem} + {1'b0, incr};
    assign carry = sum[P_INT_W];
endmodule

// File: rtl/f2i_round_conv.sv
module f2i_round_conv
    import f2i_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              to_signed,
    input  logic [1:0]        rmode,
    input  logic              force_rz,
    output logic              out_valid,
    output logic [INT_W-1:0]  out_int,
    output logic              flag_invalid,
    output logic              flag_inexact,
    output logic              flag_denorm
);
    localparam logic [INT_W-1:0] ALL_ONES = '1;
    localparam logic [INT_W-1:0] POS_MAX  = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] NEG_MAX  = {1'b1, {(INT_W-1){1'b0}}};

    fclass_t            cls;
    logic [INT_W-1:0]   ipart;
    logic [INT_W-1:0]   rem;
    logic               carry;
    rmode_e             eff_mode;
    conv_out_t          out_d, out_q;

    assign eff_mode = force_rz ? RM_ZERO : rmode_e'(rmode);

    f2i_align #(
        .P_EXP_W (EXP_W),
        .P_FRAC_W(FRAC_W),
        .P_INT_W (INT_W),
        .P_BIAS  (BIAS)
    ) u_align (
        .word (in_word),
        .cls  (cls),
        .ipart(ipart),
        .rem  (rem)
    );

    f2i_round #(
        .P_INT_W(INT_W)
    ) u_round (
        .ipart(ipart),
        .rem  (rem),
        .mode (eff_mode),
        .neg  (cls.sign),
        .carry(carry)
    );

    always_comb begin
        logic [INT_W-1:0] mag;
        logic [INT_W-1:0] lim;
        out_d     = out_q;
        out_d.vld = 1'b0;
        mag       = ipart;
        lim       = cls.sign ? NEG_MAX : POS_MAX;
        if (in_valid) begin
            out_d.vld = 1'b1;
            out_d.res = '0;
            out_d.inv = 1'b0;
            out_d.inx = 1'b0;
            out_d.den = cls.is_denorm;
            if (!to_signed) begin
                if (cls.is_nan || cls.is_big) begin
                    out_d.inv = 1'b1;
                    out_d.res = (cls.sign && !cls.is_nan) ? '0 : ALL_ONES;
                end else if (!cls.is_tiny) begin
                    if (carry) begin
                        if (mag != ALL_ONES) mag = mag + INT_W'(1);
                        else                 out_d.inv = 1'b1;
                    end
                    if (mag != '0 && cls.sign) begin
                        out_d.res = '0;
                        out_d.inv = 1'b1;
                    end else begin
                        out_d.res = mag;
                        out_d.inx = |rem;
                    end
                end else if (!cls.is_zero) begin
                    out_d.inx = 1'b1;
                    if (eff_mode == RM_UP && !cls.sign)        out_d.res = INT_W'(1);
                    else if (eff_mode == RM_DOWN && cls.sign)  out_d.inv = 1'b1;
                end
            end else begin
                if (cls.is_nan) begin
                    out_d.inv = 1'b1;
                end else if (cls.is_big) begin
                    out_d.inv = 1'b1;
                    out_d.res = lim;
                end else if (!cls.is_tiny) begin
                    if (carry && mag != ALL_ONES) mag = mag + INT_W'(1);
                    if (mag > lim) begin
                        mag       = lim;
                        out_d.inv = 1'b1;
                    end else begin
                        out_d.inx = |rem;
                    end
                    out_d.res = cls.sign ? (~mag + INT_W'(1)) : mag;
                end else if (!cls.is_zero) begin
                    out_d.inx = 1'b1;
                    if (eff_mode == RM_UP && !cls.sign)        out_d.res = INT_W'(1);
                    else if (eff_mode == RM_DOWN && cls.sign)  out_d.res = ALL_ONES;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid    = out_q.vld;
    assign out_int      = out_q.res;
    assign flag_invalid = out_q.inv;
    assign flag_inexact = out_q.inx;
    assign flag_denorm  = out_q.den;
endmodule

// File: rtl/f2i_round_conv_chk.sv
module f2i_round_conv_chk
    import f2i_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_word,
    input logic              to_signed,
    input logic [1:0]        rmode,
    input logic              force_rz,
    input logic              out_valid,
    input logic [INT_W-1:0]  out_int,
    input logic              flag_invalid,
    input logic              flag_inexact,
    input logic              flag_denorm
);
    localparam int BIG_EXP = BIAS + INT_W;
    localparam int LOW_EXP = BIAS - 1;

    logic [EXP_W-1:0] ck_exp;
    logic             ck_frac_nz;
    logic             ck_nan;
    logic             ck_tiny_nz;

    assign ck_exp     = in_word[WORD_W-2 -: EXP_W];
    assign ck_frac_nz = |in_word[FRAC_W-1:0];
    assign ck_nan     = (&ck_exp) && ck_frac_nz;
    assign ck_tiny_nz = (ck_exp < EXP_W'(LOW_EXP)) && (|in_word[WORD_W-2:0]);

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r1_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_int) && $stable(flag_invalid));

    a_r2_denorm_flag: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (flag_denorm == $past((ck_exp == '0) && ck_frac_nz)));

    a_r4_nan_signed: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && to_signed && ck_nan) |=> (out_int == '0) && flag_invalid);

    a_r4_nan_unsigned: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !to_signed && ck_nan) |=> (out_int == '1) && flag_invalid);

    a_r3_big_signed: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && to_signed && !ck_nan && ck_exp >= EXP_W'(BIG_EXP))
        |=> flag_invalid && (out_int == ($past(in_word[WORD_W-1]) ? 32'h8000_0000 : 32'h7FFF_FFFF)));

    a_r7_unsigned_negative: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !to_signed && in_word[WORD_W-1] && !ck_nan) |=> (out_int == '0));

    a_r9_tiny_inexact: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ck_tiny_nz) |=> flag_inexact);

    // R6/R9: a positive tiny value rounds to zero unless rounding upward is in effect
    a_r6_tiny_positive_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ck_tiny_nz && !in_word[WORD_W-1] && (force_rz || rmode != RM_UP))
        |=> (out_int == '0));
endmodule

bind f2i_round_conv f2i_round_conv_chk u_chk (.*);

// File: tb/tb_f2i_round_conv.sv
module tb_f2i_round_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        to_signed = 1'b0;
    logic [1:0]  rmode = 2'b00;
    logic        force_rz = 1'b0;
    logic        out_valid;
    logic [31:0] out_int;
    logic        flag_invalid, flag_inexact, flag_denorm;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    bit checking = 0;

    // driven request and its predicted result
    bit          drv_vld = 0;
    logic [31:0] drv_res = '0;
    bit          drv_inv = 0, drv_inx = 0, drv_den = 0;
    string       drv_tag = "R1";
    // expected outputs, advanced on each clock
    bit          e_vld = 0;
    logic [31:0] e_res = '0;
    bit          e_inv = 0, e_inx = 0, e_den = 0;
    string       e_tag = "R1";

    always #5 clk = ~clk;

    f2i_round_conv dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .to_signed(to_signed), .rmode(rmode), .force_rz(force_rz),
        .out_valid(out_valid), .out_int(out_int), .flag_invalid(flag_invalid),
        .flag_inexact(flag_inexact), .flag_denorm(flag_denorm)
    );

    // Exact behavioural reference
    task automatic model(input logic [31:0] w, input bit sg, input logic [1:0] rm, input bit fz,
                         output logic [31:0] r, output bit inv, output bit inx, output bit den);
        int     e   = int'(w[30:23]);
        longint m   = longint'(w[22:0]);
        bit     neg = w[31];
        int     md  = fz ? 3 : int'(rm);
        longint ip, mant, fr, half, mag, lim;
        bit     fzero, up;
        int     hc, sh;
        den = (e == 0 && m != 0);
        inv = 0; inx = 0; r = '0;
        if (e == 255 && m != 0) begin           // R4
            inv = 1; r = sg ? 32'h0 : 32'hFFFF_FFFF;
            return;
        end
        if (e >= 159) begin                     // R3
            inv = 1;
            if (sg) r = neg ? 32'h8000_0000 : 32'h7FFF_FFFF;
            else    r = neg ? 32'h0 : 32'hFFFF_FFFF;
            return;
        end
        if (e == 0 && m == 0) begin
            ip = 0; fzero = 1; hc = -1;
        end else if (e < 126) begin
            ip = 0; fzero = 0; hc = -1;
        end else begin
            mant = m | (64'd1 << 23);
            sh = 150 - e;
            if (sh <= 0) begin
                ip = mant << (-sh); fzero = 1; hc = -1;
            end else begin
                ip    = mant >> sh;
                fr    = mant & ((64'd1 << sh) - 1);
                half  = 64'd1 << (sh - 1);
                fzero = (fr == 0);
                hc    = (fr < half) ? -1 : ((fr == half) ? 0 : 1);
            end
        end
        case (md)
            0: up = (hc > 0) || (hc == 0 && ip[0]);
            1: up = !fzero && !neg;
            2: up = !fzero && neg;
            default: up = 0;
        endcase
        mag = ip + (up ? 1 : 0);
        if (sg) begin                            // R8
            lim = neg ? 64'h8000_0000 : 64'h7FFF_FFFF;
            if (mag > lim) begin
                inv = 1; r = neg ? 32'h8000_0000 : 32'h7FFF_FFFF;
            end else begin
                r = neg ? 32'(-mag) : 32'(mag);
                inx = !fzero;
            end
        end else begin
            if (neg && mag != 0) begin           // R7, tiny case of R9 keeps inexact
                inv = 1; r = '0;
                inx = (e < 126);
            end else begin
                r = 32'(mag);
                inx = !fzero;
            end
        end
    endtask

    function automatic string pick_tag(logic [31:0] w, bit sg, logic [1:0] rm, bit fz);
        int e = int'(w[30:23]);
        if (e == 255 && w[22:0] != 0) return "R4";
        if (e >= 159) return "R3";
        if (e == 0 && w[22:0] != 0) return "R2";
        if (e < 126) return "R9";
        if (fz && rm != 2'b11) return "R6";
        if (!sg && w[31]) return "R7";
        if (sg && e >= 157) return "R8";
        return "R5";
    endfunction

    task automatic drive(logic [31:0] w, bit sg, logic [1:0] rm, bit fz);
        @(posedge clk); #1;
        in_valid = 1; in_word = w; to_signed = sg; rmode = rm; force_rz = fz;
        model(w, sg, rm, fz, drv_res, drv_inv, drv_inx, drv_den);
        drv_tag = pick_tag(w, sg, rm, fz);
        drv_vld = 1;
    endtask

    task automatic idle();
        @(posedge clk); #1;
        in_valid = 0; in_word = $urandom; rmode = 2'($urandom); force_rz = 1'($urandom);
        to_signed = 1'($urandom);
        drv_vld = 0;
    endtask

    // expected-value pipeline, one register deep
    always @(posedge clk) begin
        if (!rst_n) begin
            e_vld = 0; e_res = '0; e_inv = 0; e_inx = 0; e_den = 0; e_tag = "R1";
        end else begin
            e_vld = drv_vld;
            if (drv_vld) begin
                e_res = drv_res; e_inv = drv_inv; e_inx = drv_inx; e_den = drv_den;
                e_tag = drv_tag;
            end else begin
                e_tag = "R1";
            end
        end
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h (word=%h)", tag, what, act, exp_v, in_word);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && checking) begin
            chk("R1", "out_valid", 32'(out_valid), 32'(e_vld));
            chk(e_tag, "out_int", out_int, e_res);
            chk(e_tag, "flag_invalid", 32'(flag_invalid), 32'(e_inv));
            chk(e_tag, "flag_inexact", 32'(flag_inexact), 32'(e_inx));
            chk(e_den ? "R2" : e_tag, "flag_denorm", 32'(flag_denorm), 32'(e_den));
        end
    end

    initial begin
        logic [31:0] dir [21];
        dir = '{32'h3FC0_0000, 32'h4020_0000, 32'hC020_0000, 32'h3F00_0000, 32'h3F33_3333,
                32'hBF33_3333, 32'h7FC0_0000, 32'hFFC0_0000, 32'h7F80_0000, 32'hFF80_0000,
                32'h4F00_0000, 32'hCF00_0000, 32'h4F80_0000, 32'h4F7F_FFFF, 32'h0000_0001,
                32'h8000_0001, 32'h0000_0000, 32'h8000_0000, 32'h3E99_999A, 32'hBE99_999A,
                32'h42F6_E979};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset out_valid", 32'(out_valid), 32'h0);
        chk("R1", "reset out_int", out_int, 32'h0);
        chk("R1", "reset flags", {29'h0, flag_invalid, flag_inexact, flag_denorm}, 32'h0);
        @(posedge clk); #1 rst_n = 1;
        checking = 1;
        // directed corners under every form/mode/override combination (R3..R9)
        for (int i = 0; i < 21; i++)
            for (int c = 0; c < 16; c++) begin
                drive(dir[i], c[0], c[2:1], c[3]);
                if (c == 7) idle();
            end
        idle(); idle();
        // random sweep around the integer range
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] w;
            w = $urandom;
            if (k % 4 != 0) w[30:23] = 8'(110 + ($urandom % 60));
            if (k % 13 == 0) w[30:23] = 8'h00;
            drive(w, 1'($urandom), 2'($urandom), ($urandom % 4) == 0);
            if ($urandom % 5 == 0) idle();
        end
        idle(); idle(); idle();
        checking = 0;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule